// File: doc/BRIEF.md
# Bus-Master DMA Channel Status Register

This block holds the one-byte status word for a single channel of a bus-master DMA disk controller. Three kinds of bit share the byte. Sticky flags are set by event pulses from the DMA engine, the host-bus interface and the device link, and software clears them by writing one. Two capability bits belong to software, which reads and writes them freely. An activity flag is owned by hardware: it follows the start and the end of a transfer.

The register sits on a simple register bus with a byte-wide write strobe and a combinational read. Each instance answers only at its own address, which is set by a parameter. The primary channel uses offset 02h and the secondary channel uses offset 0Ah. The block combines the two interrupt-type flags into one level-sensitive interrupt request. The DMA engine, the descriptor fetch and the link layer are not part of this block. They appear only as single-cycle event inputs.

Top module: `dma_chan_status`

## Requirements
- R1: After reset the byte reads 00h and `irq` is low.
- R2: Bit 7 (descriptor interrupt) sets one cycle after a pulse on `ev_desc_irq`. A write with data bit 7 = 1 clears it. A write with data bit 7 = 0 leaves it unchanged.
- R3: Bit 2 (device interrupt) sets after `ev_dev_frame_irq` only while `dev_irq_en` is 1. With `dev_irq_en` = 0 the frame is ignored. Writing 1 to bit 2 clears it.
- R4: Bit 1 (bus error) sets after `ev_bus_abort`. Writing 1 to bit 1 clears it.
- R5: Bits 6 and 5 (drive 1 and drive 0 capable) hold whatever was last written to them. They affect neither `irq` nor any other bit.
- R6: Bits 4:3 always read 0, whatever data is written.
- R7: Bit 0 (active) sets after a `start_set` pulse. Register writes never change it.
- R8: Bit 0 clears after `ev_eot_done` or after `start_clear`. If `start_set` arrives in the same cycle as either of them, bit 0 ends up set.
- R9: When a set event and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R10: `irq` is high exactly while bit 7 or bit 2 is set. It stays low for flags in bits 1, 0, 6 and 5.
- R11: A write changes the register only when `bus_addr` equals the instance's `OFFSET`. When the address does not match, `bus_rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ev_desc_irq | input | 1 | Pulse: a descriptor carrying an interrupt request has finished |
| ev_dev_frame_irq | input | 1 | Pulse: a device frame arrived with its interrupt bit set |
| dev_irq_en | input | 1 | Device interrupt-enable state; 0 means device interrupts are disabled |
| ev_bus_abort | input | 1 | Pulse: target or master abort during a host-bus transfer |
| start_set | input | 1 | Pulse: software wrote the start bit to 1 |
| start_clear | input | 1 | Pulse: software cleared the start bit |
| ev_eot_done | input | 1 | Pulse: the last transfer of an end-of-table region completed |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the event inputs and the start and stop inputs are single-cycle pulses sampled on the rising edge, and that the address and write data are stable whenever `bus_wr` is high. They also assume that the only thing that can set bit 2 is a device frame while interrupts are enabled. The bench drives every input on the falling edge and releases each pulse one cycle later. It holds `dev_irq_en` steady around each frame. Collisions between events and clears are produced on purpose, within the same cycle, to exercise the priority rules.

// File: rtl/dma_chan_status.sv
module dma_chan_status #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ev_desc_irq,
  input  logic              ev_dev_frame_irq,
  input  logic              dev_irq_en,
  input  logic              ev_bus_abort,
  input  logic              start_set,
  input  logic              start_clear,
  input  logic              ev_eot_done,
  output logic              irq
);
  localparam int B_DESC = 7;
  localparam int B_CAP1 = 6;
  localparam int B_CAP0 = 5;
  localparam int B_DEV  = 2;
  localparam int B_ERR  = 1;

  logic       sel, wr_hit;
  logic       desc_f, dev_f, err_f, act;
  logic [1:0] cap;
  logic [7:0] stat;

  assign sel    = (bus_addr == OFFSET);
  assign wr_hit = bus_wr & sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              desc_f <= 1'b0;
    else if (ev_desc_irq)                    desc_f <= 1'b1;
    else if (wr_hit && bus_wdata[B_DESC])    desc_f <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              dev_f <= 1'b0;
    else if (ev_dev_frame_irq && dev_irq_en) dev_f <= 1'b1;
    else if (wr_hit && bus_wdata[B_DEV])     dev_f <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              err_f <= 1'b0;
    else if (ev_bus_abort)                   err_f <= 1'b1;
    else if (wr_hit && bus_wdata[B_ERR])     err_f <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cap <= 2'b00;
    else if (wr_hit)  cap <= {bus_wdata[B_CAP1], bus_wdata[B_CAP0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           act <= 1'b0;
    else if (start_set)                   act <= 1'b1;
    else if (start_clear || ev_eot_done)  act <= 1'b0;

  assign stat      = {desc_f, cap, 2'b00, dev_f, err_f, act};
  assign bus_rdata = sel ? stat : 8'h00;
  assign irq       = desc_f | dev_f;
endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 'h02
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              ev_desc_irq,
  input logic              ev_dev_frame_irq,
  input logic              dev_irq_en,
  input logic              ev_bus_abort,
  input logic              start_set,
  input logic              start_clear,
  input logic              ev_eot_done,
  input logic              irq,
  input logic [7:0]        stat
);
  logic hit;
  assign hit = bus_wr && (bus_addr == OFFSET);

  p_desc_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_irq |=> stat[7]);
  p_desc_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit && bus_wdata[7] && !ev_desc_irq |=> !stat[7]);
  p_frame_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[2] && !(ev_dev_frame_irq && dev_irq_en) |=> !stat[2]);
  p_abort_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_abort |=> stat[1]);
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[4:3] == 2'b00);
  p_active_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_set |=> stat[0]);
  p_active_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_set && !start_clear && !ev_eot_done |=> $stable(stat[0]));
  p_active_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_clear || ev_eot_done) && !start_set |=> !stat[0]);
  p_irq_desc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_irq |=> irq);
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[7] && !stat[2] |-> !irq);
  p_unaddressed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr != OFFSET |-> bus_rdata == 8'h00);
endmodule

bind dma_chan_status dma_chan_status_chk #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_desc_irq(ev_desc_irq),
  .ev_dev_frame_irq(ev_dev_frame_irq), .dev_irq_en(dev_irq_en),
  .ev_bus_abort(ev_bus_abort), .start_set(start_set), .start_clear(start_clear),
  .ev_eot_done(ev_eot_done), .irq(irq), .stat(stat)
);

// File: tb/dma_chan_status_test.sv
module dma_chan_status_test;
  localparam logic [7:0] PRI = 8'h02;
  localparam logic [7:0] SEC = 8'h0A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = PRI, bus_wdata = 8'h00;
  logic bus_wr = 1'b0;
  logic ev_desc = 1'b0, ev_frame = 1'b0, irq_en = 1'b1, ev_abort = 1'b0;
  logic st_set = 1'b0, st_clr = 1'b0, ev_eot = 1'b0, ev_desc_b = 1'b0;
  logic [7:0] rd_a, rd_b;
  logic irq_a, irq_b;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_chan_status #(.ADDR_W(8), .OFFSET(PRI)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .ev_desc_irq(ev_desc),
    .ev_dev_frame_irq(ev_frame), .dev_irq_en(irq_en), .ev_bus_abort(ev_abort),
    .start_set(st_set), .start_clear(st_clr), .ev_eot_done(ev_eot), .irq(irq_a));

  dma_chan_status #(.ADDR_W(8), .OFFSET(SEC)) uut_sec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_b), .ev_desc_irq(ev_desc_b),
    .ev_dev_frame_irq(1'b0), .dev_irq_en(1'b0), .ev_bus_abort(1'b0),
    .start_set(1'b0), .start_clear(1'b0), .ev_eot_done(1'b0), .irq(irq_b));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    @(negedge clk);
    bus_wr = 0; ev_desc = 0; ev_frame = 0; ev_abort = 0;
    st_set = 0; st_clr = 0; ev_eot = 0; ev_desc_b = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    idle();
  endtask

  task automatic chk_rd(input logic [7:0] a, input bit sec, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    bus_addr = a; #1;
    got = sec ? rd_b : rd_a;
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: rdata actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq_a !== exp) begin
      errors++;
      $display("FAIL %s: irq actual %0b expected %0b", tag, irq_a, exp);
    end
  endtask

  task automatic t_reset();
    chk_rd(PRI, 0, 8'h00, "R1 primary");
    chk_rd(SEC, 1, 8'h00, "R1 secondary");
    chk_irq(0, "R1");
  endtask

  task automatic t_desc();
    @(negedge clk); ev_desc = 1; idle();
    chk_rd(PRI, 0, 8'h80, "R2 set");
    chk_irq(1, "R10 desc");
    wr(PRI, 8'h00);
    chk_rd(PRI, 0, 8'h80, "R2 write zero keeps");
    wr(PRI, 8'h80);
    chk_rd(PRI, 0, 8'h00, "R2 w1c");
    chk_irq(0, "R10 cleared");
  endtask

  task automatic t_device();
    irq_en = 0;
    @(negedge clk); ev_frame = 1; idle();
    chk_rd(PRI, 0, 8'h00, "R3 masked");
    irq_en = 1;
    @(negedge clk); ev_frame = 1; idle();
    chk_rd(PRI, 0, 8'h04, "R3 set");
    chk_irq(1, "R10 device");
    wr(PRI, 8'h04);
    chk_rd(PRI, 0, 8'h00, "R3 w1c");
  endtask

  task automatic t_abort();
    @(negedge clk); ev_abort = 1; idle();
    chk_rd(PRI, 0, 8'h02, "R4 set");
    chk_irq(0, "R10 error no irq");
    wr(PRI, 8'h02);
    chk_rd(PRI, 0, 8'h00, "R4 w1c");
  endtask

  task automatic t_cap();
    wr(PRI, 8'h60);
    chk_rd(PRI, 0, 8'h60, "R5 both");
    chk_irq(0, "R5 no irq");
    wr(PRI, 8'h20);
    chk_rd(PRI, 0, 8'h20, "R5 drive0 only");
    wr(PRI, 8'hFF);
    chk_rd(PRI, 0, 8'h60, "R6 reserved and R7 bit0 ignore write");
    wr(PRI, 8'h00);
    chk_rd(PRI, 0, 8'h00, "R5 cleared");
  endtask

  task automatic t_active();
    @(negedge clk); st_set = 1; idle();
    chk_rd(PRI, 0, 8'h01, "R7 start");
    chk_irq(0, "R10 active no irq");
    wr(PRI, 8'h01);
    chk_rd(PRI, 0, 8'h01, "R7 write ignored");
    @(negedge clk); ev_eot = 1; idle();
    chk_rd(PRI, 0, 8'h00, "R8 eot");
    @(negedge clk); st_set = 1; idle();
    @(negedge clk); st_clr = 1; idle();
    chk_rd(PRI, 0, 8'h00, "R8 stop");
    @(negedge clk); st_set = 1; ev_eot = 1; idle();
    chk_rd(PRI, 0, 8'h01, "R8 start beats eot");
    @(negedge clk); st_set = 1; st_clr = 1; idle();
    chk_rd(PRI, 0, 8'h01, "R8 start beats stop");
    @(negedge clk); st_clr = 1; idle();
    chk_rd(PRI, 0, 8'h00, "R8 final stop");
  endtask

  task automatic t_race();
    @(negedge clk); ev_desc = 1; bus_addr = PRI; bus_wdata = 8'h80; bus_wr = 1; idle();
    chk_rd(PRI, 0, 8'h80, "R9 desc set wins");
    @(negedge clk); ev_abort = 1; bus_addr = PRI; bus_wdata = 8'h82; bus_wr = 1; idle();
    chk_rd(PRI, 0, 8'h02, "R9 abort set wins, desc cleared");
    wr(PRI, 8'h02);
    chk_rd(PRI, 0, 8'h00, "R9 cleanup");
  endtask

  task automatic t_offset();
    wr(SEC, 8'h60);
    chk_rd(SEC, 1, 8'h60, "R11 secondary write");
    chk_rd(PRI, 0, 8'h00, "R11 primary untouched");
    chk_rd(SEC, 0, 8'h00, "R11 primary not addressed");
    chk_rd(PRI, 1, 8'h00, "R11 secondary not addressed");
    @(negedge clk); ev_desc_b = 1; idle();
    chk_rd(SEC, 1, 8'he0, "R11 secondary event");
    chk_irq(0, "R11 primary irq low");
    wr(PRI, 8'h80);
    chk_rd(SEC, 1, 8'he0, "R11 primary clear misses secondary");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_desc();
    t_device();
    t_abort();
    t_cap();
    t_active();
    t_race();
    t_offset();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule